// File: doc/BRIEF.md
# In-Band Flow Control Calendar Assembler

This block sits behind the receive control-word decoder of a packet link. Each control word carries a small slice of flow-control status, called a page. Burst control words and Idle control words carry pages in the same way, and both feed a single page sequence. The block collects these pages and presents them as one wide calendar register. The application then maps that calendar onto its channels.

A sequence starts at a control word whose calendar-restart flag is set. That word supplies the most significant page. The following control words supply the remaining pages, in order toward the least significant end. The output register is written only when a sequence is complete. A one-cycle strobe marks every change of the output value. If a new sequence starts before the current one is complete, the partial sequence is dropped and a one-cycle error pulse is raised.

Top module: `cal_assembler`

## Requirements
- R1: After reset, `cal_out` is zero and both `cal_upd` and `cal_seq_err` are low.
- R2: A word counts as a control word only when `cw_vld` is high and `cw_kind` is 1 (Burst) or 2 (Idle). For a control word, the page is `cw_word[55:40]` and the calendar-restart flag is `cw_word[56]`. Kinds 0 (data) and 3 (reserved) have no effect, whatever their bits hold.
- R3: Control words that arrive before the first control word with the restart flag set have no effect on `cal_out`.
- R4: The page from the restart word lands in `cal_out[63:48]`. The next three pages land in `cal_out[47:32]`, `cal_out[31:16]` and `cal_out[15:0]`, in that order.
- R5: `cal_out` changes only on the clock edge after the fourth page of a sequence is accepted. It holds its value at all other times.
- R6: A cycle with `cw_vld` low has no effect on the sequence, whatever `cw_kind` and `cw_word` hold.
- R7: A restart word that arrives after one to three pages of a sequence have been collected does three things. It raises `cal_seq_err` for exactly one cycle, on the edge after that word. It discards the partial sequence. It becomes page 0 of a new sequence. A restart word that arrives while no sequence is open raises no error.
- R8: `cal_upd` is high for one cycle exactly when `cal_out` takes a new value. A completed sequence that produces the current value again does not raise it.
- R9: After a sequence completes, control words without the restart flag have no effect until the next restart word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_vld | input | 1 | The word on `cw_word` is valid this cycle |
| cw_kind | input | 2 | Word kind: 0 data, 1 Burst, 2 Idle, 3 reserved |
| cw_word | input | 64 | Decoded 64-bit link word |
| cal_out | output | 64 | Assembled calendar |
| cal_upd | output | 1 | One-cycle pulse when `cal_out` changes |
| cal_seq_err | output | 1 | One-cycle pulse when a sequence is cut short |

## Verification
The hardest case to reach from the ports is a restart word landing at each possible fill level of a sequence. The same applies to a completed sequence that reproduces the value already held, which must not strobe. The bench drives every 8-bit pattern of restart flags over short runs of words. Word kinds and the valid bit rotate from one word to the next, so truncation occurs at every fill level, and it occurs between both kinds of control word and ignored words. A bench model written from the requirements predicts the calendar, strobe and error for every cycle. Directed runs repeat an identical calendar and also send pages ahead of the first restart word.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [1:0] {
      CW_DATA  = 2'd0,
      CW_BURST = 2'd1,
      CW_IDLE  = 2'd2,
      CW_RSVD  = 2'd3
   } cw_kind_e;
endpackage

// File: rtl/cal_word_decode.sv
module cal_word_decode
   import cal_pkg::*;
#(
   parameter int WORD_W   = 64,
   parameter int PAGE_W   = 16,
   parameter int PAGE_LSB = 40,
   parameter int RST_BIT  = 56
) (
   input  logic              vld,
   input  logic [1:0]        kind,
   input  logic [WORD_W-1:0] word,
   output logic              evt,
   output logic              rst_flag,
   output logic [PAGE_W-1:0] page
);
   cw_kind_e kind_e;

   always_comb begin
      kind_e   = cw_kind_e'(kind);
      evt      = vld && ((kind_e == CW_BURST) || (kind_e == CW_IDLE));
      rst_flag = word[RST_BIT];
      page     = word[PAGE_LSB +: PAGE_W];
   end
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
   parameter int NPAGES = 4,
   localparam int CNT_W = $clog2(NPAGES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic              rst_flag,
   output logic [NPAGES-1:0] lane_sel,
   output logic              done,
   output logic              err_q
);
   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   for (genvar i = 0; i < NPAGES; i++) begin : g_sel
      if (i == 0) begin : g_first
         assign lane_sel[i] = evt && (rst_flag || (active_q && cnt_q == CNT_W'(0)));
      end else begin : g_rest
         assign lane_sel[i] = evt && !rst_flag && active_q && (cnt_q == CNT_W'(i));
      end
   end

   assign done = evt && !rst_flag && active_q && (cnt_q == CNT_W'(NPAGES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= evt && rst_flag && active_q && (cnt_q != '0);
         if (evt) begin
            if (rst_flag) begin
               active_q <= 1'b1;
               cnt_q    <= CNT_W'(1);
            end else if (active_q) begin
               if (cnt_q == CNT_W'(NPAGES - 1)) begin
                  active_q <= 1'b0;
                  cnt_q    <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         end
      end
   end

   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> $past(evt && rst_flag));
   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(NPAGES));
   p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> ($stable(cnt_q) && $stable(active_q)));
   p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_sel));
endmodule

// File: rtl/cal_page_store.sv
module cal_page_store #(
   parameter int PAGE_W = 16,
   parameter int NPAGES = 4,
   localparam int CAL_W = PAGE_W * NPAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] page,
   input  logic [NPAGES-1:0] lane_sel,
   input  logic              done,
   output logic [CAL_W-1:0]  cal_q,
   output logic              upd_q
);
   logic [NPAGES-2:0][PAGE_W-1:0] lane_q;
   logic [CAL_W-1:0]              full_w;

   for (genvar i = 0; i < NPAGES - 1; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)           lane_q[i] <= '0;
         else if (lane_sel[i]) lane_q[i] <= page;
      end
      assign full_w[(NPAGES-1-i)*PAGE_W +: PAGE_W] = lane_q[i];
   end
   assign full_w[PAGE_W-1:0] = page;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cal_q <= '0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= done && (full_w != cal_q);
         if (done) cal_q <= full_w;
      end
   end

   p_upd_is_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (cal_q != $past(cal_q)));
   p_hold_no_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |-> $stable(cal_q));
endmodule

// File: rtl/cal_assembler.sv
module cal_assembler #(
   parameter int WORD_W   = 64,
   parameter int PAGE_W   = 16,
   parameter int NPAGES   = 4,
   parameter int PAGE_LSB = 40,
   parameter int RST_BIT  = 56,
   localparam int CAL_W   = PAGE_W * NPAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_vld,
   input  logic [1:0]        cw_kind,
   input  logic [WORD_W-1:0] cw_word,
   output logic [CAL_W-1:0]  cal_out,
   output logic              cal_upd,
   output logic              cal_seq_err
);
   if (NPAGES < 2) begin : g_bad_npages
      $error("cal_assembler: NPAGES must be at least 2");
   end
   if (PAGE_LSB + PAGE_W > WORD_W) begin : g_bad_field
      $error("cal_assembler: page field exceeds word width");
   end
   if (RST_BIT >= WORD_W || (RST_BIT >= PAGE_LSB && RST_BIT < PAGE_LSB + PAGE_W)) begin : g_bad_rst
      $error("cal_assembler: restart bit misplaced");
   end

   logic              evt;
   logic              rst_flag;
   logic [PAGE_W-1:0] page;
   logic [NPAGES-1:0] lane_sel;
   logic              done;

   cal_word_decode #(
      .WORD_W(WORD_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB), .RST_BIT(RST_BIT)
   ) u_dec (
      .vld(cw_vld), .kind(cw_kind), .word(cw_word),
      .evt(evt), .rst_flag(rst_flag), .page(page)
   );

   cal_seq_ctrl #(.NPAGES(NPAGES)) u_seq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .rst_flag(rst_flag),
      .lane_sel(lane_sel), .done(done), .err_q(cal_seq_err)
   );

   cal_page_store #(.PAGE_W(PAGE_W), .NPAGES(NPAGES)) u_store (
      .clk(clk), .rst_n(rst_n), .page(page), .lane_sel(lane_sel),
      .done(done), .cal_q(cal_out), .upd_q(cal_upd)
   );

   p_err_upd_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_seq_err && cal_upd));
endmodule

// File: tb/sim_cal_assembler.sv
module sim_cal_assembler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_vld = 1'b0;
   logic [1:0]  cw_kind = 2'd0;
   logic [63:0] cw_word = '0;
   logic [63:0] cal_out;
   logic        cal_upd;
   logic        cal_seq_err;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   logic        m_sync = 1'b0;
   int          m_cnt = 0;
   logic [63:0] m_acc = '0;
   logic [63:0] m_cal = '0;
   logic        m_upd = 1'b0;
   logic        m_err = 1'b0;

   always #10 clk = ~clk;

   cal_assembler u0 (
      .clk(clk), .rst_n(rst_n), .cw_vld(cw_vld), .cw_kind(cw_kind),
      .cw_word(cw_word), .cal_out(cal_out), .cal_upd(cal_upd),
      .cal_seq_err(cal_seq_err)
   );

   function automatic logic [63:0] mkword(bit rf, logic [15:0] pg, logic [63:0] noise);
      logic [63:0] w;
      w = noise;
      w[55:40] = pg;
      w[56] = rf;
      return w;
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model(bit vld, logic [1:0] kind, logic [63:0] w);
      m_upd = 1'b0;
      m_err = 1'b0;
      if (vld && (kind == 2'd1 || kind == 2'd2)) begin
         if (w[56]) begin
            m_err  = m_sync && (m_cnt >= 1) && (m_cnt <= 3);
            m_acc  = {w[55:40], 48'h0};
            m_cnt  = 1;
            m_sync = 1'b1;
         end else if (m_sync) begin
            m_acc = m_acc | ({48'h0, w[55:40]} << (48 - 16 * m_cnt));
            m_cnt++;
            if (m_cnt == 4) begin
               m_upd  = (m_acc != m_cal);
               m_cal  = m_acc;
               m_sync = 1'b0;
               m_cnt  = 0;
            end
         end
      end
   endtask

   task automatic step(string tag, bit vld, logic [1:0] kind, logic [63:0] w);
      @(negedge clk);
      cw_vld  = vld;
      cw_kind = kind;
      cw_word = w;
      model(vld, kind, w);
      @(posedge clk);
      #5;
      chk({tag, " R4 R5"}, "cal_out", cal_out, m_cal);
      chk({tag, " R8"}, "cal_upd", {63'h0, cal_upd}, {63'h0, m_upd});
      chk({tag, " R7"}, "cal_seq_err", {63'h0, cal_seq_err}, {63'h0, m_err});
   endtask

   task automatic seq4(string tag, logic [1:0] kind, logic [63:0] val);
      for (int i = 0; i < 4; i++)
         step(tag, 1'b1, kind, mkword(i == 0, val[63-16*i -: 16], 64'hA5A5_0000_0000_5A5A));
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #5;
      // R1: reset state
      chk("R1", "cal_out", cal_out, 64'h0);
      chk("R1", "cal_upd", {63'h0, cal_upd}, 64'h0);
      chk("R1", "cal_seq_err", {63'h0, cal_seq_err}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: pages before the first restart flag are ignored
      for (int i = 0; i < 5; i++)
         step("R3", 1'b1, 2'd1, mkword(1'b0, 16'hBEE0 + 16'(i), 64'h0));
      chk("R3", "cal_out unchanged", cal_out, 64'h0);

      // R2 R4: mixed Burst/Idle, noise outside the page field
      step("R2", 1'b1, 2'd1, mkword(1'b1, 16'h1111, 64'hFFFF_0000_0000_FFFF));
      step("R2", 1'b1, 2'd0, mkword(1'b1, 16'hDEAD, 64'h0));
      step("R2", 1'b1, 2'd2, mkword(1'b0, 16'h2222, 64'h0123_0000_0000_4567));
      step("R2", 1'b1, 2'd3, mkword(1'b0, 16'hDEAD, 64'h0));
      // R6: valid low ignored
      step("R6", 1'b0, 2'd1, mkword(1'b1, 16'hDEAD, 64'h0));
      step("R2", 1'b1, 2'd1, mkword(1'b0, 16'h3333, 64'h0));
      step("R4", 1'b1, 2'd2, mkword(1'b0, 16'h4444, 64'h0));
      chk("R4", "layout", cal_out, 64'h1111_2222_3333_4444);

      // R9: pages after completion without restart are ignored
      for (int i = 0; i < 4; i++)
         step("R9", 1'b1, 2'd2, mkword(1'b0, 16'h9000 + 16'(i), 64'h0));
      chk("R9", "cal_out held", cal_out, 64'h1111_2222_3333_4444);

      // R8: identical calendar produces no strobe
      seq4("R8", 2'd1, 64'h1111_2222_3333_4444);
      seq4("R8", 2'd2, 64'hCAFE_0001_0002_0003);

      // R7: truncation at each fill level
      for (int f = 1; f <= 3; f++) begin
         step("R7", 1'b1, 2'd1, mkword(1'b1, 16'h7000, 64'h0));
         for (int k = 1; k < f; k++)
            step("R7", 1'b1, 2'd2, mkword(1'b0, 16'h7100 + 16'(k), 64'h0));
      end
      seq4("R7", 2'd1, 64'h0F0F_1E1E_2D2D_3C3C);

      // Sweep: all 8-bit restart patterns with rotating kinds and valid
      for (int p = 0; p < 256; p++) begin
         for (int w = 0; w < 8; w++) begin
            logic [1:0] kd;
            bit vv;
            kd = 2'((p + w) % 4);
            vv = ((p + 3 * w) % 7) != 0;
            if ((w % 3) == 1) kd = 2'd1;
            step("SWEEP", vv, kd,
                 mkword(p[w], 16'(p * 251 + w * 4099 + 17), 64'(p) << 8));
         end
      end

      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule